// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block decides which low-power state the chip occupies and drives the digital controls that go with each state: clock enables for the core and the peripherals, a low-power hint to the regulator, a core-domain power-off request and an internal core reset. The core raises a one-cycle sleep request together with its deep-sleep bit and a flag that says whether it waits for an interrupt or for an event. Two control bits then choose between Sleep, Stop and Standby. Stop exit inserts a settling wait whose length depends on the regulator setting. Standby exit passes through a timed internal reset before Run resumes.

A small register pair holds the configuration and the sticky flags. The control word (address 0) holds the regulator select, the power-down select, two write-one flag clears, the voltage-detector enable and level, and the backup-domain write enable. The status word (address 1) holds the wakeup flag, the standby flag, the detector output and the wakeup-pin enables. Register writes take effect only while the block is in Run. The analog detector, the oscillators and the regulator stay outside; they appear only as digital inputs and outputs.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset, mode_o is 0 (Run), both clock enables are 1, core_pwr_off_o, core_rst_o and reg_lp_o are 0, and both register words read 0.
- R2: In Run, a sleep_req_i with deep_i=0 moves mode_o to 1 (Sleep) on the next cycle, with core_clk_en_o=0 and periph_clk_en_o=1.
- R3: A wait-for-interrupt entry (sleep_wfe_i=0) leaves Sleep or Stop only on irq_i and ignores evt_i. A wait-for-event entry (sleep_wfe_i=1) leaves only on evt_i and ignores irq_i.
- R4: A wakeup that is already present in the request cycle cancels the entry and mode_o stays 0. For Sleep and Stop this is the matching irq_i or evt_i. For Standby it is any Standby wake source.
- R5: A sleep_req_i with deep_i=1 and control bit 1 clear enters mode 2 (Stop). Both clock enables are 0, and reg_lp_o equals control bit 0 as it was at entry.
- R6: A Stop wakeup passes through mode 3 for exactly ON_WAIT cycles (control bit 0 = 0) or LP_WAIT cycles (bit 0 = 1). hsi_force_o is then high for exactly the first Run cycle.
- R7: A sleep_req_i with deep_i=1 and control bit 1 set enters mode 4 (Standby). core_pwr_off_o is 1, both clock enables are 0, det_en_o is 0, and det_out_o is 0 from the second Standby cycle on.
- R8: Standby ends on a rising edge of a wakeup pin whose enable bit is set (status bits 10:8, pin n at bit 8+n), or on alarm_i, tamper_i, tstamp_i, ext_rst_i or wdg_rst_i. An edge on a disabled pin has no effect. The block then spends exactly RST_CYCLES cycles in mode 5 with core_rst_o=1 and returns to Run. The control word reads 0 afterwards and the pin enables are kept.
- R9: Status bit 0 (wakeup flag) is set by an enabled pin edge, alarm_i, tamper_i or tstamp_i, but not by ext_rst_i or wdg_rst_i. Status bit 1 (standby flag) is set on every Standby exit. Writing 1 to control bit 2 clears bit 0, and writing 1 to control bit 3 clears bit 1. The clear bits read back 0.
- R10: bkp_wr_en_o follows bkp_wr_req_i only while control bit 8 is set. It is 0 after reset.
- R11: det_en_o is control bit 4 outside Standby, and det_level_o is control bits 7:5. det_out_o (also status bit 2) is det_raw_i ANDed with det_en_o, registered one cycle. det_evt_o pulses for one cycle in each cycle in which det_out_o changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | 0 = control word, 1 = status word |
| reg_wdata_i | input | 8+NUM_PINS | Write data |
| reg_rdata_o | output | 8+NUM_PINS | Read data for reg_addr_i (combinational) |
| sleep_req_i | input | 1 | One-cycle sleep request from the core |
| sleep_wfe_i | input | 1 | 1 = wait for event, 0 = wait for interrupt |
| deep_i | input | 1 | Core deep-sleep bit |
| irq_i | input | 1 | Acknowledged interrupt |
| evt_i | input | 1 | Event pulse |
| wkup_pin_i | input | NUM_PINS | Wakeup pins |
| alarm_i | input | 1 | Alarm wake |
| tamper_i | input | 1 | Tamper wake |
| tstamp_i | input | 1 | Timestamp wake |
| ext_rst_i | input | 1 | External reset wake |
| wdg_rst_i | input | 1 | Watchdog reset wake |
| det_raw_i | input | 1 | Voltage comparator result |
| bkp_wr_req_i | input | 1 | Backup-domain write request |
| mode_o | output | 3 | 0 Run, 1 Sleep, 2 Stop, 3 Stop wake wait, 4 Standby, 5 Standby exit reset |
| core_clk_en_o | output | 1 | Core clock enable |
| periph_clk_en_o | output | 1 | Peripheral clock enable |
| reg_lp_o | output | 1 | Regulator low-power request |
| core_pwr_off_o | output | 1 | Core domain power-off |
| core_rst_o | output | 1 | Internal core reset |
| hsi_force_o | output | 1 | Pulse: select internal RC clock |
| det_en_o | output | 1 | Detector enable |
| det_level_o | output | 3 | Detector threshold select |
| det_out_o | output | 1 | Detector output flag |
| det_evt_o | output | 1 | Detector edge event |
| bkp_wr_en_o | output | 1 | Gated backup write enable |

## Verification
Stop is entered repeatedly with the regulator setting and the entry kind drawn at random. Before the correct source arrives, the wrong wake source is pulsed, which separates wait-for-event from wait-for-interrupt. The measured length of the wake wait separates the two regulator settings. Directed runs cover a wakeup present at entry, an edge on a disabled pin next to an enabled one, and each Standby source in turn. Together these separate the flag-setting sources from the reset-only sources and show what survives the exit reset.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [2:0] {
    M_RUN       = 3'd0,
    M_SLEEP     = 3'd1,
    M_STOP      = 3'd2,
    M_STOP_WAKE = 3'd3,
    M_STANDBY   = 3'd4,
    M_SB_RST    = 3'd5
  } pmc_mode_e;

  localparam int unsigned CTL_LP      = 0;
  localparam int unsigned CTL_PDDS    = 1;
  localparam int unsigned CTL_DET_EN  = 4;
  localparam int unsigned CTL_LVL_LSB = 5;
  localparam int unsigned CTL_BKP     = 8;
  localparam int unsigned STS_WU      = 0;
  localparam int unsigned STS_SB      = 1;
  localparam int unsigned STS_DET     = 2;
  localparam int unsigned STS_PIN_LSB = 8;
  localparam int unsigned CLR_OFS     = 2;
endpackage

// File: rtl/pmc_wake.sv
module pmc_wake #(
  parameter int unsigned NUM_PINS = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic [NUM_PINS-1:0] pin_en_i,
  input  logic                alarm_i,
  input  logic                tamper_i,
  input  logic                tstamp_i,
  input  logic                ext_rst_i,
  input  logic                wdg_rst_i,
  output logic                flag_evt_o,
  output logic                sb_wake_o
);
  logic [NUM_PINS-1:0] pin_q;
  logic [NUM_PINS-1:0] pin_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_q <= '0;
    else         pin_q <= pin_i;
  end

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    assign pin_rise[g] = pin_i[g] & ~pin_q[g] & pin_en_i[g];
  end

  assign flag_evt_o = (|pin_rise) | alarm_i | tamper_i | tstamp_i;
  assign sb_wake_o  = flag_evt_o | ext_rst_i | wdg_rst_i;
endmodule

// File: rtl/pmc_regs.sv
module pmc_regs
  import pmc_pkg::*;
#(
  parameter int unsigned NUM_PINS = 3,
  parameter int unsigned DATA_W   = 11
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                core_rst_i,
  input  logic                wr_en_i,
  input  logic                addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  input  logic                wuf_set_i,
  input  logic                sbf_set_i,
  input  logic                det_raw_i,
  input  logic                det_off_i,
  input  logic                bkp_wr_req_i,
  output logic                lp_o,
  output logic                pdds_o,
  output logic                det_en_o,
  output logic [2:0]          det_lvl_o,
  output logic                bkp_wr_en_o,
  output logic [NUM_PINS-1:0] pin_en_o,
  output logic                sbf_o,
  output logic                det_out_o,
  output logic                det_evt_o
);
  logic lp_q, pdds_q, pvde_q, dbp_q, wuf_q, sbf_q, det_q, evt_q;
  logic [2:0] lvl_q;
  logic [NUM_PINS-1:0] pen_q;
  logic wr_ctl, wr_sts, det_next;

  assign wr_ctl = wr_en_i & ~addr_i;
  assign wr_sts = wr_en_i & addr_i;

  // core-domain control bits, cleared by the standby-exit reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      {lp_q, pdds_q, pvde_q, dbp_q} <= '0;
      lvl_q <= '0;
    end else if (core_rst_i) begin
      {lp_q, pdds_q, pvde_q, dbp_q} <= '0;
      lvl_q <= '0;
    end else if (wr_ctl) begin
      lp_q   <= wdata_i[CTL_LP];
      pdds_q <= wdata_i[CTL_PDDS];
      pvde_q <= wdata_i[CTL_DET_EN];
      lvl_q  <= wdata_i[CTL_LVL_LSB +: 3];
      dbp_q  <= wdata_i[CTL_BKP];
    end
  end

  // standby-circuitry state survives the exit reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pen_q <= '0;
      wuf_q <= 1'b0;
      sbf_q <= 1'b0;
    end else begin
      if (wr_sts) pen_q <= wdata_i[STS_PIN_LSB +: NUM_PINS];
      if (wuf_set_i)                                 wuf_q <= 1'b1;
      else if (wr_ctl && wdata_i[STS_WU + CLR_OFS])  wuf_q <= 1'b0;
      if (sbf_set_i)                                 sbf_q <= 1'b1;
      else if (wr_ctl && wdata_i[STS_SB + CLR_OFS])  sbf_q <= 1'b0;
    end
  end

  assign det_en_o = pvde_q & ~det_off_i;
  assign det_next = det_en_o & det_raw_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      det_q <= 1'b0;
      evt_q <= 1'b0;
    end else begin
      det_q <= det_next;
      evt_q <= det_next ^ det_q;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (!addr_i) begin
      rdata_o[CTL_LP]             = lp_q;
      rdata_o[CTL_PDDS]           = pdds_q;
      rdata_o[CTL_DET_EN]         = pvde_q;
      rdata_o[CTL_LVL_LSB +: 3]   = lvl_q;
      rdata_o[CTL_BKP]            = dbp_q;
    end else begin
      rdata_o[STS_WU]                   = wuf_q;
      rdata_o[STS_SB]                   = sbf_q;
      rdata_o[STS_DET]                  = det_q;
      rdata_o[STS_PIN_LSB +: NUM_PINS]  = pen_q;
    end
  end

  assign lp_o        = lp_q;
  assign pdds_o      = pdds_q;
  assign det_lvl_o   = lvl_q;
  assign bkp_wr_en_o = bkp_wr_req_i & dbp_q;
  assign pin_en_o    = pen_q;
  assign sbf_o       = sbf_q;
  assign det_out_o   = det_q;
  assign det_evt_o   = evt_q;
endmodule

// File: rtl/pmc_fsm.sv
module pmc_fsm
  import pmc_pkg::*;
#(
  parameter int unsigned ON_WAIT    = 2,
  parameter int unsigned LP_WAIT    = 6,
  parameter int unsigned RST_CYCLES = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sleep_req_i,
  input  logic       sleep_wfe_i,
  input  logic       deep_i,
  input  logic       pdds_i,
  input  logic       lp_i,
  input  logic       irq_i,
  input  logic       evt_i,
  input  logic       sb_wake_i,
  output logic [2:0] mode_o,
  output logic       core_clk_en_o,
  output logic       periph_clk_en_o,
  output logic       reg_lp_o,
  output logic       core_pwr_off_o,
  output logic       core_rst_o,
  output logic       hsi_force_o,
  output logic       sbf_set_o
);
  localparam int unsigned MAX_W = (LP_WAIT > ON_WAIT) ?
    ((LP_WAIT > RST_CYCLES) ? LP_WAIT : RST_CYCLES) :
    ((ON_WAIT > RST_CYCLES) ? ON_WAIT : RST_CYCLES);
  localparam int unsigned CW = $clog2(MAX_W + 1);

  pmc_mode_e st_q, st_d;
  logic wfe_q, wfe_d, lp_q, lp_d, hsi_q, hsi_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic entry_pend, exit_hit;

  assign entry_pend = sleep_wfe_i ? evt_i : irq_i;
  assign exit_hit   = wfe_q ? evt_i : irq_i;

  always_comb begin
    st_d      = st_q;
    wfe_d     = wfe_q;
    lp_d      = lp_q;
    cnt_d     = cnt_q;
    hsi_d     = 1'b0;
    sbf_set_o = 1'b0;
    unique case (st_q)
      M_RUN: if (sleep_req_i) begin
        if (!deep_i || !pdds_i) begin
          if (!entry_pend) begin
            st_d  = deep_i ? M_STOP : M_SLEEP;
            wfe_d = sleep_wfe_i;
            lp_d  = lp_i;
          end
        end else if (!sb_wake_i) begin
          st_d = M_STANDBY;
        end
      end
      M_SLEEP: if (exit_hit) st_d = M_RUN;
      M_STOP: if (exit_hit) begin
        st_d  = M_STOP_WAKE;
        cnt_d = lp_q ? CW'(LP_WAIT - 1) : CW'(ON_WAIT - 1);
      end
      M_STOP_WAKE: begin
        if (cnt_q == '0) begin
          st_d  = M_RUN;
          hsi_d = 1'b1;
        end else cnt_d = cnt_q - 1'b1;
      end
      M_STANDBY: if (sb_wake_i) begin
        st_d      = M_SB_RST;
        cnt_d     = CW'(RST_CYCLES - 1);
        sbf_set_o = 1'b1;
      end
      M_SB_RST: begin
        if (cnt_q == '0) st_d = M_RUN;
        else             cnt_d = cnt_q - 1'b1;
      end
      default: st_d = M_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= M_RUN;
      wfe_q <= 1'b0;
      lp_q  <= 1'b0;
      hsi_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      wfe_q <= wfe_d;
      lp_q  <= lp_d;
      hsi_q <= hsi_d;
      cnt_q <= cnt_d;
    end
  end

  assign mode_o          = st_q;
  assign core_clk_en_o   = (st_q == M_RUN) || (st_q == M_SB_RST);
  assign periph_clk_en_o = core_clk_en_o || (st_q == M_SLEEP);
  assign reg_lp_o        = (st_q == M_STOP) && lp_q;
  assign core_pwr_off_o  = (st_q == M_STANDBY);
  assign core_rst_o      = (st_q == M_SB_RST);
  assign hsi_force_o     = hsi_q;
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int unsigned NUM_PINS   = 3,
  parameter int unsigned ON_WAIT    = 2,
  parameter int unsigned LP_WAIT    = 6,
  parameter int unsigned RST_CYCLES = 4,
  localparam int unsigned DATA_W    = STS_PIN_LSB + NUM_PINS
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                reg_we_i,
  input  logic                reg_addr_i,
  input  logic [DATA_W-1:0]   reg_wdata_i,
  output logic [DATA_W-1:0]   reg_rdata_o,
  input  logic                sleep_req_i,
  input  logic                sleep_wfe_i,
  input  logic                deep_i,
  input  logic                irq_i,
  input  logic                evt_i,
  input  logic [NUM_PINS-1:0] wkup_pin_i,
  input  logic                alarm_i,
  input  logic                tamper_i,
  input  logic                tstamp_i,
  input  logic                ext_rst_i,
  input  logic                wdg_rst_i,
  input  logic                det_raw_i,
  input  logic                bkp_wr_req_i,
  output logic [2:0]          mode_o,
  output logic                core_clk_en_o,
  output logic                periph_clk_en_o,
  output logic                reg_lp_o,
  output logic                core_pwr_off_o,
  output logic                core_rst_o,
  output logic                hsi_force_o,
  output logic                det_en_o,
  output logic [2:0]          det_level_o,
  output logic                det_out_o,
  output logic                det_evt_o,
  output logic                bkp_wr_en_o
);
  logic flag_evt, sb_wake, sbf_set, sb_flag, lp, pdds, wr_run;
  logic [NUM_PINS-1:0] pin_en;

  assign wr_run = reg_we_i & (mode_o == M_RUN);

  pmc_wake #(.NUM_PINS(NUM_PINS)) u_wake (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(wkup_pin_i), .pin_en_i(pin_en),
    .alarm_i(alarm_i), .tamper_i(tamper_i), .tstamp_i(tstamp_i),
    .ext_rst_i(ext_rst_i), .wdg_rst_i(wdg_rst_i),
    .flag_evt_o(flag_evt), .sb_wake_o(sb_wake)
  );

  pmc_regs #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .core_rst_i(core_rst_o),
    .wr_en_i(wr_run), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o), .wuf_set_i(flag_evt), .sbf_set_i(sbf_set),
    .det_raw_i(det_raw_i), .det_off_i(core_pwr_off_o),
    .bkp_wr_req_i(bkp_wr_req_i), .lp_o(lp), .pdds_o(pdds),
    .det_en_o(det_en_o), .det_lvl_o(det_level_o), .bkp_wr_en_o(bkp_wr_en_o),
    .pin_en_o(pin_en), .sbf_o(sb_flag), .det_out_o(det_out_o),
    .det_evt_o(det_evt_o)
  );

  pmc_fsm #(.ON_WAIT(ON_WAIT), .LP_WAIT(LP_WAIT), .RST_CYCLES(RST_CYCLES)) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .sleep_req_i(sleep_req_i),
    .sleep_wfe_i(sleep_wfe_i), .deep_i(deep_i), .pdds_i(pdds), .lp_i(lp),
    .irq_i(irq_i), .evt_i(evt_i), .sb_wake_i(sb_wake), .mode_o(mode_o),
    .core_clk_en_o(core_clk_en_o), .periph_clk_en_o(periph_clk_en_o),
    .reg_lp_o(reg_lp_o), .core_pwr_off_o(core_pwr_off_o),
    .core_rst_o(core_rst_o), .hsi_force_o(hsi_force_o), .sbf_set_o(sbf_set)
  );
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [2:0] mode_o,
  input logic       sleep_req_i,
  input logic       sleep_wfe_i,
  input logic       deep_i,
  input logic       irq_i,
  input logic       hsi_force_o,
  input logic       sb_flag,
  input logic       det_out_o,
  input logic       det_evt_o,
  input logic       core_pwr_off_o,
  input logic       core_rst_o
);
  a_r4_pending_irq_aborts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd0 && sleep_req_i && !deep_i && !sleep_wfe_i && irq_i) |=> mode_o == 3'd0);

  a_r5_stop_needs_deep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd2 && $past(mode_o) == 3'd0) |-> $past(deep_i));

  a_r6_hsi_after_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hsi_force_o |-> (mode_o == 3'd0 && $past(mode_o) == 3'd3));

  a_r7_det_off_standby: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd4 && $past(mode_o) == 3'd4) |-> !det_out_o);

  a_r8_reset_after_standby: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(core_pwr_off_o) |-> core_rst_o);

  a_r9_sbf_on_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd5 && $past(mode_o) == 3'd4) |-> sb_flag);

  a_r11_evt_on_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    det_evt_o |-> det_out_o != $past(det_out_o));
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mode_o(mode_o), .sleep_req_i(sleep_req_i),
  .sleep_wfe_i(sleep_wfe_i), .deep_i(deep_i), .irq_i(irq_i),
  .hsi_force_o(hsi_force_o), .sb_flag(sb_flag), .det_out_o(det_out_o),
  .det_evt_o(det_evt_o), .core_pwr_off_o(core_pwr_off_o), .core_rst_o(core_rst_o)
);

// File: tb/pwr_mode_ctrl_tb_top.sv
module pwr_mode_ctrl_tb_top;
  localparam int NP = 3, ONW = 2, LPW = 6, RSTC = 4, DW = 8 + NP;

  logic clk_i = 0, rst_ni = 0;
  logic reg_we_i = 0, reg_addr_i = 0;
  logic [DW-1:0] reg_wdata_i = '0, reg_rdata_o;
  logic sleep_req_i = 0, sleep_wfe_i = 0, deep_i = 0, irq_i = 0, evt_i = 0;
  logic [NP-1:0] wkup_pin_i = '0;
  logic alarm_i = 0, tamper_i = 0, tstamp_i = 0, ext_rst_i = 0, wdg_rst_i = 0;
  logic det_raw_i = 0, bkp_wr_req_i = 0;
  logic [2:0] mode_o, det_level_o;
  logic core_clk_en_o, periph_clk_en_o, reg_lp_o, core_pwr_off_o, core_rst_o;
  logic hsi_force_o, det_en_o, det_out_o, det_evt_o, bkp_wr_en_o;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  pwr_mode_ctrl #(.NUM_PINS(NP), .ON_WAIT(ONW), .LP_WAIT(LPW), .RST_CYCLES(RSTC)) dut_i (.*);

  function automatic int exp_wait(bit lp);
    return lp ? LPW : ONW;
  endfunction

  function automatic logic [DW-1:0] exp_status(bit wu, bit sb, bit det, logic [NP-1:0] pen);
    return {pen, 5'b0, det, sb, wu};
  endfunction

  task automatic step(int n = 1);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(bit a, logic [DW-1:0] d);
    reg_addr_i = a; reg_wdata_i = d; reg_we_i = 1;
    step();
    reg_we_i = 0;
  endtask

  task automatic rd(bit a, output logic [DW-1:0] v);
    reg_addr_i = a;
    #1;
    v = reg_rdata_o;
  endtask

  task automatic request(bit deep, bit wfe);
    sleep_req_i = 1; deep_i = deep; sleep_wfe_i = wfe;
    step();
    sleep_req_i = 0; deep_i = 0;
  endtask

  // count cycles spent in a given mode, starting with the current sample
  task automatic dwell(logic [2:0] m, output int n);
    n = 0;
    while (mode_o == m && n < 100) begin n++; step(); end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] v;
    int n;
    void'($urandom(32'h5eed_0042));
    step(2);
    rst_ni = 1;
    step();

    // R1 reset state
    chk("R1 mode", mode_o, 0);
    chk("R1 clocks", {core_clk_en_o, periph_clk_en_o}, 2'b11);
    chk("R1 power", {core_pwr_off_o, core_rst_o, reg_lp_o}, 0);
    rd(0, v); chk("R1 ctl", v, 0);
    rd(1, v); chk("R1 sts", v, 0);

    // R10 backup gate
    bkp_wr_req_i = 1; #1;
    chk("R10 blocked after reset", bkp_wr_en_o, 0);
    wr(0, 11'h100);
    chk("R10 enabled", bkp_wr_en_o, 1);
    wr(0, 11'h000);
    chk("R10 disabled again", bkp_wr_en_o, 0);
    bkp_wr_req_i = 0;

    // R11 detector
    wr(0, 11'((1 << 4) | (5 << 5)));
    chk("R11 enable", det_en_o, 1);
    chk("R11 level", det_level_o, 5);
    det_raw_i = 1; step();
    chk("R11 out rise", det_out_o, 1);
    chk("R11 evt rise", det_evt_o, 1);
    step();
    chk("R11 evt single", det_evt_o, 0);
    rd(1, v); chk("R11 status bit", v[2], 1);
    det_raw_i = 0; step();
    chk("R11 evt fall", {det_out_o, det_evt_o}, 2'b01);
    det_raw_i = 1; step(2);

    // R2 / R3 Sleep with WFI
    request(0, 0);
    chk("R2 sleep mode", mode_o, 1);
    chk("R2 sleep clocks", {core_clk_en_o, periph_clk_en_o}, 2'b01);
    evt_i = 1; step(); evt_i = 0;
    chk("R3 wfi ignores evt", mode_o, 1);
    irq_i = 1; step(); irq_i = 0;
    chk("R3 wfi exit on irq", mode_o, 0);

    // R3 Sleep with WFE
    request(0, 1);
    irq_i = 1; step(); irq_i = 0;
    chk("R3 wfe ignores irq", mode_o, 1);
    evt_i = 1; step(); evt_i = 0;
    chk("R3 wfe exit on evt", mode_o, 0);

    // R4 pending wake aborts entry
    irq_i = 1; request(0, 0); irq_i = 0;
    chk("R4 pending irq", mode_o, 0);
    evt_i = 1; request(1, 1); evt_i = 0;
    chk("R4 pending evt stop", mode_o, 0);

    // R5 / R6 random Stop entries
    for (int i = 0; i < 12; i++) begin
      bit lp, wfe;
      int idle;
      lp = 1'($urandom); wfe = 1'($urandom); idle = int'($urandom % 4);
      wr(0, 11'((1 << 4) | (5 << 5) | lp));
      request(1, wfe);
      chk("R5 stop mode", mode_o, 2);
      chk("R5 stop clocks", {core_clk_en_o, periph_clk_en_o}, 0);
      chk("R5 regulator", reg_lp_o, lp);
      for (int k = 0; k < idle; k++) begin
        if (wfe) irq_i = 1; else evt_i = 1;
        step(); irq_i = 0; evt_i = 0;
      end
      chk("R3 stop holds on wrong source", mode_o, 2);
      if (wfe) evt_i = 1; else irq_i = 1;
      step(); irq_i = 0; evt_i = 0;
      dwell(3, n);
      chk("R6 wake wait", n, exp_wait(lp));
      chk("R6 run + hsi", {mode_o, hsi_force_o}, 4'b0001);
      step();
      chk("R6 hsi single", hsi_force_o, 0);
    end

    // R7 / R8 / R9 Standby via enabled pin
    wr(1, 11'h200);
    wr(0, 11'h100 | 11'((1 << 4) | 2));
    request(1, 0);
    chk("R7 standby mode", mode_o, 4);
    chk("R7 power off", {core_pwr_off_o, core_clk_en_o, periph_clk_en_o, det_en_o}, 4'b1000);
    step();
    chk("R7 det forced off", det_out_o, 0);
    wkup_pin_i[0] = 1; step();
    chk("R8 disabled pin ignored", mode_o, 4);
    wkup_pin_i[1] = 1; step();
    chk("R8 exit reset", {mode_o, core_rst_o}, 4'b1011);
    dwell(5, n);
    chk("R8 reset length", n, RSTC);
    chk("R8 back to run", mode_o, 0);
    rd(0, v); chk("R8 ctl cleared", v, 0);
    rd(1, v); chk("R9 flags + pin enables kept", v, exp_status(1, 1, 0, 3'b010));
    wkup_pin_i = '0;

    // R9 write-one clears
    wr(0, 11'h004);
    rd(1, v); chk("R9 clear wakeup", v[1:0], 2'b10);
    wr(0, 11'h008);
    rd(1, v); chk("R9 clear standby", v[1:0], 2'b00);
    rd(0, v); chk("R9 clear bits read 0", v, 0);

    // R8 / R9 each non-pin source
    for (int s = 0; s < 5; s++) begin
      wr(0, 11'h00E);
      request(1, 0);
      chk("R8 standby again", mode_o, 4);
      case (s)
        0: alarm_i = 1;
        1: tamper_i = 1;
        2: tstamp_i = 1;
        3: ext_rst_i = 1;
        default: wdg_rst_i = 1;
      endcase
      step();
      {alarm_i, tamper_i, tstamp_i, ext_rst_i, wdg_rst_i} = '0;
      chk("R8 source exits", mode_o, 5);
      step(RSTC);
      rd(1, v);
      chk("R9 source flags", v[1:0], (s < 3) ? 2'b11 : 2'b10);
    end

    // R4 standby source present at entry
    wr(0, 11'h00E);
    alarm_i = 1; request(1, 0); alarm_i = 0;
    chk("R4 pending standby source", mode_o, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule